// File: doc/BRIEF.md
# Banked Scratchpad Conflict Resolver

The resolver takes one access from a group of 32 lanes to a scratchpad built from 32 banks, each one 4-byte word wide. A request carries a byte address per lane, a mask of participating lanes, an access size code and a read/write flag. The resolver works out which bank holds each lane's word and where that word sits in the bank. It then issues a series of passes. In each pass every bank is given at most one row address, and a served mask shows which lanes that pass completes. Lanes that ask for the same word share one pass, so one read is multicast to all of them. Lanes that ask for different rows of the same bank are spread over successive passes.

Wide accesses are cut into phases. An 8-byte access runs as two half-group phases, lanes 0-15 first and then lanes 16-31. A 16-byte access runs as four phases of eight lanes each. Bank clashes are counted only between lanes of the same phase. When the last phase is done, a one-cycle done pulse comes out together with the number of passes used. Byte and half-word accesses use the 4-byte code.

The control is a four-state machine. In IDLE it is ready and a valid request moves it to ISSUE (transition accept). In ISSUE it drives one pass per cycle while the current phase still has pending lanes. When the phase is empty it goes to STEP (transition next-phase), or to FINISH if the phase was the last one (transition last-phase). STEP moves the phase pointer on and returns to ISSUE (transition resume). FINISH raises done and returns to IDLE (transition retire).

Top module: `spad_conflict_resolver`

## Requirements
- R1: The word index of a lane is its byte address divided by 4. The bank is the word index modulo 32 and the row is the word index divided by 32. Address bits 1:0 are ignored.
- R2: All pending lanes of a phase whose word matches the word a bank serves in a pass are marked in `lane_served` in that pass. The lanes of one word therefore never take more than one pass.
- R3: When a phase holds N distinct rows in one bank, that phase takes N passes. A column walk with 32 lanes on rows 0..31 of bank 0 takes 32 passes, which is 31 replays.
- R4: In each pass, every bank serves the row of the lowest-numbered pending lane of the current phase that maps to it. A bank that no pending lane maps to has `bank_en` low and drives zero on its row and source fields.
- R5: Width code 1 (8 bytes) clears word bit 0. A lane then uses banks 2k and 2k+1, and lanes 0-15 are handled in phase 0 before lanes 16-31 in phase 1.
- R6: Width code 2 (16 bytes) clears word bits 1:0. A lane then uses four aligned banks, and lanes 8p..8p+7 form phase p, for p from 0 to 3. Codes 0 and 3 are 4-byte accesses with all lanes in one phase.
- R7: Lanes in different phases never add passes to each other. The pass total equals the sum over phases of the largest number of distinct rows in any bank.
- R8: In every pass, `bank_src` of an enabled bank names the highest-numbered lane served by that bank in that pass. That lane's data wins on a write. `pass_write` repeats the request's write flag during passes.
- R9: Inactive lanes are never served and add no passes. A phase with no active lanes issues no pass. A request with no active lanes ends with done and a pass total of 0.
- R10: `done` is a single-cycle pulse that follows the last pass. `pass_total` equals the number of cycles in which `pass_valid` was high for that request, and holds until the next request. `req_ready` is high only in IDLE.
- R11: After reset, `req_ready` is high, `pass_valid` and `done` are low and `pass_total` is 0.
- R12: A column walk over a 32-word-wide array has 32 lanes in one bank. A padded stride of 33 words per lane gives 32 distinct banks and finishes in a single pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present; taken when req_ready is high |
| req_ready | output | 1 | Resolver idle and able to take a request |
| req_addr | input | LANES*ADDR_W | Byte address per lane, lane l at bits l*ADDR_W upward |
| req_active | input | LANES | Participating lanes |
| req_width | input | 2 | Size code: 0 = 4 B, 1 = 8 B, 2 = 16 B, 3 = 4 B |
| req_write | input | 1 | 1 for a write, 0 for a read |
| pass_valid | output | 1 | A pass is driven this cycle |
| pass_write | output | 1 | Write flag of the request, during passes |
| bank_en | output | BANKS | Banks accessed in this pass |
| bank_row | output | BANKS*ROW_W | Row address per bank |
| bank_src | output | BANKS*LANE_W | Highest served lane per bank (write winner) |
| lane_served | output | LANES | Lanes completed by this pass |
| done | output | 1 | One-cycle pulse after the last pass |
| pass_total | output | CNT_W | Passes used by the latest request |

## Verification
Multicast merging and conflict serialisation both act in the same pass. In a single cycle, one bank can serve a word shared by several lanes while a lane with a different row in that bank is held back for the next pass. The bench provokes this with shared-word, two-row and random requests that mix duplicates and clashes in one phase. It judges every pass-valid cycle against a behavioural model that lists each pass's bank enables, rows, served lanes and write winners. The done pulse and the pass count are judged in the cycle after the last pass. The count is also checked against an independent formula: the sum over phases of the largest number of distinct rows in any bank.

// File: rtl/spad_pkg.sv
package spad_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ISSUE  = 2'd1,
        ST_STEP   = 2'd2,
        ST_FINISH = 2'd3
    } rs_state_e;

    // Words per lane, which is also the number of phases.
    function automatic int span_words(input logic [1:0] wcode);
        case (wcode)
            2'd1:    return 2;
            2'd2:    return 4;
            default: return 1;
        endcase
    endfunction

    // Phase a lane belongs to for a given size code.
    function automatic int phase_of(input int lane, input int lanes, input logic [1:0] wcode);
        return lane / (lanes / span_words(wcode));
    endfunction

endpackage

// File: rtl/spad_lane_decode.sv
module spad_lane_decode #(
    parameter int LANES  = 32,
    parameter int BANKS  = 32,
    parameter int ADDR_W = 12,
    localparam int BANK_W = $clog2(BANKS),
    localparam int WORD_W = ADDR_W - 2,
    localparam int ROW_W  = WORD_W - BANK_W
) (
    input  logic [LANES*ADDR_W-1:0]        addr_flat,
    input  logic [1:0]                     width,
    output logic [BANK_W-1:0]              align_mask,
    output logic [LANES-1:0][BANK_W-1:0]   base_bank,
    output logic [LANES-1:0][ROW_W-1:0]    lane_row
);

    always_comb begin
        case (width)
            2'd1:    align_mask = ~BANK_W'(1);
            2'd2:    align_mask = ~BANK_W'(3);
            default: align_mask = '1;
        endcase
    end

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            logic [WORD_W-1:0] word;
            assign word         = addr_flat[l*ADDR_W+2 +: WORD_W];
            assign base_bank[l] = word[BANK_W-1:0] & align_mask;
            assign lane_row[l]  = word[WORD_W-1:BANK_W];
        end
    endgenerate

endmodule

// File: rtl/spad_bank_pick.sv
module spad_bank_pick #(
    parameter int LANES  = 32,
    parameter int BANKS  = 32,
    parameter int ADDR_W = 12,
    localparam int BANK_W = $clog2(BANKS),
    localparam int LANE_W = $clog2(LANES),
    localparam int ROW_W  = ADDR_W - 2 - BANK_W
) (
    input  logic [LANES-1:0]               cand,
    input  logic [BANK_W-1:0]              align_mask,
    input  logic [LANES-1:0][BANK_W-1:0]   base_bank,
    input  logic [LANES-1:0][ROW_W-1:0]    lane_row,
    output logic [BANKS-1:0]               bank_en,
    output logic [BANKS-1:0][ROW_W-1:0]    bank_row,
    output logic [BANKS-1:0][LANE_W-1:0]   bank_src
);

    generate
        for (genvar b = 0; b < BANKS; b++) begin : g_bank
            logic [LANES-1:0]  covers;
            logic [ROW_W-1:0]  sel_row;
            logic [LANE_W-1:0] sel_src;

            always_comb begin
                for (int l = 0; l < LANES; l++) begin
                    covers[l] = cand[l] && ((BANK_W'(b) & align_mask) == base_bank[l]);
                end
            end

            // Lowest covering lane picks the row; highest lane on that row is the source.
            always_comb begin
                sel_row = '0;
                for (int l = LANES - 1; l >= 0; l--) begin
                    if (covers[l]) sel_row = lane_row[l];
                end
                sel_src = '0;
                for (int l = 0; l < LANES; l++) begin
                    if (covers[l] && (lane_row[l] == sel_row)) sel_src = LANE_W'(l);
                end
            end

            assign bank_en[b]  = |covers;
            assign bank_row[b] = sel_row;
            assign bank_src[b] = sel_src;
        end
    endgenerate

endmodule

// File: rtl/spad_serve_map.sv
module spad_serve_map #(
    parameter int LANES  = 32,
    parameter int BANKS  = 32,
    parameter int ADDR_W = 12,
    localparam int BANK_W = $clog2(BANKS),
    localparam int ROW_W  = ADDR_W - 2 - BANK_W
) (
    input  logic [LANES-1:0]               cand,
    input  logic [LANES-1:0][BANK_W-1:0]   base_bank,
    input  logic [LANES-1:0][ROW_W-1:0]    lane_row,
    input  logic [BANKS-1:0][ROW_W-1:0]    bank_row,
    output logic [LANES-1:0]               served
);

    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            served[l] = cand[l] && (lane_row[l] == bank_row[base_bank[l]]);
        end
    end

endmodule

// File: rtl/spad_conflict_resolver.sv
module spad_conflict_resolver
    import spad_pkg::*;
#(
    parameter int LANES  = 32,
    parameter int BANKS  = 32,
    parameter int ADDR_W = 12,
    localparam int BANK_W = $clog2(BANKS),
    localparam int LANE_W = $clog2(LANES),
    localparam int ROW_W  = ADDR_W - 2 - BANK_W,
    localparam int CNT_W  = $clog2(LANES + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [LANES*ADDR_W-1:0]   req_addr,
    input  logic [LANES-1:0]          req_active,
    input  logic [1:0]                req_width,
    input  logic                      req_write,
    output logic                      pass_valid,
    output logic                      pass_write,
    output logic [BANKS-1:0]          bank_en,
    output logic [BANKS*ROW_W-1:0]    bank_row,
    output logic [BANKS*LANE_W-1:0]   bank_src,
    output logic [LANES-1:0]          lane_served,
    output logic                      done,
    output logic [CNT_W-1:0]          pass_total
);

    rs_state_e                  state_q, state_d;
    logic [LANES*ADDR_W-1:0]    addr_q;
    logic [LANES-1:0]           pend_q;
    logic [1:0]                 width_q;
    logic                       write_q;
    logic [1:0]                 phase_q;
    logic [CNT_W-1:0]           cnt_q;

    logic [LANES-1:0]           phase_mask;
    logic [LANES-1:0]           cand;
    logic [LANES-1:0]           served;
    logic [LANES-1:0]           rest;
    logic                       last_phase;
    logic                       issuing;

    logic [BANK_W-1:0]              align_mask;
    logic [LANES-1:0][BANK_W-1:0]   base_bank;
    logic [LANES-1:0][ROW_W-1:0]    lane_row;
    logic [BANKS-1:0]               pick_en;
    logic [BANKS-1:0][ROW_W-1:0]    pick_row;
    logic [BANKS-1:0][LANE_W-1:0]   pick_src;

    spad_lane_decode #(.LANES(LANES), .BANKS(BANKS), .ADDR_W(ADDR_W)) u_decode (
        .addr_flat (addr_q),
        .width     (width_q),
        .align_mask(align_mask),
        .base_bank (base_bank),
        .lane_row  (lane_row)
    );

    spad_bank_pick #(.LANES(LANES), .BANKS(BANKS), .ADDR_W(ADDR_W)) u_pick (
        .cand      (cand),
        .align_mask(align_mask),
        .base_bank (base_bank),
        .lane_row  (lane_row),
        .bank_en   (pick_en),
        .bank_row  (pick_row),
        .bank_src  (pick_src)
    );

    spad_serve_map #(.LANES(LANES), .BANKS(BANKS), .ADDR_W(ADDR_W)) u_serve (
        .cand      (cand),
        .base_bank (base_bank),
        .lane_row  (lane_row),
        .bank_row  (pick_row),
        .served    (served)
    );

    // Lanes of the current phase still waiting.
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            phase_mask[l] = (phase_of(l, LANES, width_q) == int'(phase_q));
        end
        cand       = pend_q & phase_mask;
        rest       = cand & ~served;
        last_phase = (int'(phase_q) == span_words(width_q) - 1);
        issuing    = (state_q == ST_ISSUE) && (cand != '0);
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_ISSUE;
            ST_ISSUE:  if (rest == '0) state_d = last_phase ? ST_FINISH : ST_STEP;
            ST_STEP:   state_d = ST_ISSUE;
            ST_FINISH: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Request and progress registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            pend_q  <= '0;
            width_q <= '0;
            write_q <= 1'b0;
            phase_q <= '0;
            cnt_q   <= '0;
        end else begin
            if (state_q == ST_IDLE && req_valid) begin
                addr_q  <= req_addr;
                pend_q  <= req_active;
                width_q <= req_width;
                write_q <= req_write;
                phase_q <= '0;
                cnt_q   <= '0;
            end else begin
                if (issuing) begin
                    pend_q <= pend_q & ~served;
                    cnt_q  <= cnt_q + CNT_W'(1);
                end
                if (state_q == ST_STEP) phase_q <= phase_q + 2'd1;
            end
        end
    end

    // Outputs
    always_comb begin
        req_ready   = (state_q == ST_IDLE);
        done        = (state_q == ST_FINISH);
        pass_valid  = issuing;
        pass_write  = issuing && write_q;
        pass_total  = cnt_q;
        bank_en     = issuing ? pick_en : '0;
        lane_served = issuing ? served  : '0;
        for (int b = 0; b < BANKS; b++) begin
            bank_row[b*ROW_W +: ROW_W]   = (issuing && pick_en[b]) ? pick_row[b] : '0;
            bank_src[b*LANE_W +: LANE_W] = (issuing && pick_en[b]) ? pick_src[b] : '0;
        end
    end

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    ready_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> req_ready);

    // R9
    served_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pass_valid |=> ((pend_q & $past(lane_served)) == '0));

    // R2
    pass_progress_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pass_valid |-> (lane_served != '0));

    // R9
    served_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pass_valid |-> ((lane_served & ~pend_q) == '0));

    // R3
    pass_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pass_valid |-> (int'(cnt_q) < LANES));

endmodule

// File: tb/spad_conflict_resolver_tb.sv
`timescale 1ns/1ps
module spad_conflict_resolver_tb;

    localparam int L  = 32;
    localparam int B  = 32;
    localparam int AW = 12;
    localparam int RW = 5;
    localparam int SW = 5;
    localparam int CW = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [L*AW-1:0]   req_addr = '0;
    logic [L-1:0]      req_active = '0;
    logic [1:0]        req_width = '0;
    logic              req_write = 1'b0;
    logic              pass_valid, pass_write, done;
    logic [B-1:0]      bank_en;
    logic [B*RW-1:0]   bank_row;
    logic [B*SW-1:0]   bank_src;
    logic [L-1:0]      lane_served;
    logic [CW-1:0]     pass_total;

    int checks = 0;
    int errors = 0;
    int addr_arr [L];

    always #4 clk = ~clk;

    spad_conflict_resolver u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_active(req_active), .req_width(req_width),
        .req_write(req_write), .pass_valid(pass_valid), .pass_write(pass_write),
        .bank_en(bank_en), .bank_row(bank_row), .bank_src(bank_src),
        .lane_served(lane_served), .done(done), .pass_total(pass_total)
    );

    task automatic check(input bit ok, input string req, input string act, input string exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%s expected=%s", req, act, exp);
        end
    endtask

    function automatic int spanw(input logic [1:0] w);
        return (w == 2'd1) ? 2 : ((w == 2'd2) ? 4 : 1);
    endfunction
    function automatic int row_of(input int a);
        return ((a >> 2) & 1023) / 32;
    endfunction
    function automatic int base_of(input int a, input int sw);
        return (((a >> 2) & 1023) % 32) & ~(sw - 1);
    endfunction

    logic [B-1:0]    q_en[$];
    logic [L-1:0]    q_srv[$];
    logic [B*RW-1:0] q_row[$];
    logic [B*SW-1:0] q_src[$];

    task automatic run_req(input logic [L-1:0] act, input logic [1:0] w,
                           input logic wr, input string tag);
        int sw, lpp, exp_total, form_total, cyc;
        bit finished;
        sw = spanw(w);
        lpp = L / sw;
        exp_total = 0;
        form_total = 0;
        q_en.delete(); q_srv.delete(); q_row.delete(); q_src.delete();
        // Behavioural pass list
        for (int ph = 0; ph < sw; ph++) begin
            logic [L-1:0] pend = '0;
            for (int l = ph*lpp; l < (ph+1)*lpp; l++) if (act[l]) pend[l] = 1'b1;
            while (pend != '0) begin
                int winrow [B];
                logic [B-1:0] en = '0;
                logic [L-1:0] srv = '0;
                logic [B*RW-1:0] rv = '0;
                logic [B*SW-1:0] sv = '0;
                for (int b = 0; b < B; b++) begin
                    winrow[b] = -1;
                    for (int l = 0; l < L; l++)
                        if (pend[l] && ((b & ~(sw-1)) == base_of(addr_arr[l], sw)) && winrow[b] < 0)
                            winrow[b] = row_of(addr_arr[l]);
                    en[b] = (winrow[b] >= 0);
                end
                for (int l = 0; l < L; l++)
                    if (pend[l] && row_of(addr_arr[l]) == winrow[base_of(addr_arr[l], sw)]) srv[l] = 1'b1;
                for (int b = 0; b < B; b++) if (en[b]) begin
                    rv[b*RW +: RW] = RW'(winrow[b]);
                    for (int l = 0; l < L; l++)
                        if (srv[l] && ((b & ~(sw-1)) == base_of(addr_arr[l], sw))) sv[b*SW +: SW] = SW'(l);
                end
                q_en.push_back(en); q_srv.push_back(srv); q_row.push_back(rv); q_src.push_back(sv);
                pend &= ~srv;
                exp_total++;
            end
            // Independent count: widest bank of the phase
            begin
                int mx = 0;
                for (int b = 0; b < B; b++) begin
                    int rows_seen [$];
                    for (int l = ph*lpp; l < (ph+1)*lpp; l++)
                        if (act[l] && ((b & ~(sw-1)) == base_of(addr_arr[l], sw))) begin
                            int r = row_of(addr_arr[l]);
                            bit dup = 0;
                            foreach (rows_seen[i]) if (rows_seen[i] == r) dup = 1;
                            if (!dup) rows_seen.push_back(r);
                        end
                    if (rows_seen.size() > mx) mx = rows_seen.size();
                end
                form_total += mx;
            end
        end
        // Drive
        @(negedge clk);
        for (int l = 0; l < L; l++) req_addr[l*AW +: AW] = AW'(addr_arr[l]);
        req_active = act; req_width = w; req_write = wr; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        finished = 0;
        cyc = 0;
        while (!finished && cyc < 300) begin
            check(req_ready == 1'b0, {tag, " R10 ready low while busy"}, $sformatf("%0b", req_ready), "0");
            if (pass_valid) begin
                if (q_en.size() == 0) begin
                    check(0, {tag, " R3 unexpected pass"}, "pass", "none");
                end else begin
                    logic [B-1:0] e = q_en.pop_front();
                    logic [L-1:0] s = q_srv.pop_front();
                    logic [B*RW-1:0] r = q_row.pop_front();
                    logic [B*SW-1:0] c = q_src.pop_front();
                    check(bank_en == e, {tag, " R4 bank_en"}, $sformatf("%h", bank_en), $sformatf("%h", e));
                    check(bank_row == r, {tag, " R1 bank_row"}, $sformatf("%h", bank_row), $sformatf("%h", r));
                    check(lane_served == s, {tag, " R2 lane_served"}, $sformatf("%h", lane_served), $sformatf("%h", s));
                    check(bank_src == c, {tag, " R8 bank_src"}, $sformatf("%h", bank_src), $sformatf("%h", c));
                    check(pass_write == wr, {tag, " R8 pass_write"}, $sformatf("%0b", pass_write), $sformatf("%0b", wr));
                end
            end
            if (done) begin
                finished = 1;
                check(q_en.size() == 0, {tag, " R10 passes left at done"}, $sformatf("%0d", q_en.size()), "0");
                check(int'(pass_total) == exp_total, {tag, " R10 pass_total"}, $sformatf("%0d", pass_total), $sformatf("%0d", exp_total));
                check(int'(pass_total) == form_total, {tag, " R7 pass_total formula"}, $sformatf("%0d", pass_total), $sformatf("%0d", form_total));
            end
            @(negedge clk);
            cyc++;
        end
        if (!finished) check(0, {tag, " R10 watchdog"}, "no done", "done");
        else begin
            check(req_ready && !done, {tag, " R10 idle after done"}, $sformatf("%0b%0b", req_ready, done), "10");
            check(int'(pass_total) == exp_total, {tag, " R10 total held"}, $sformatf("%0d", pass_total), $sformatf("%0d", exp_total));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "watchdog", "timeout", "finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check(req_ready == 1'b1 && !pass_valid && !done && pass_total == '0, "R11 reset",
              $sformatf("%0b%0b%0b%0d", req_ready, pass_valid, done, pass_total), "1000");
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1 && !pass_valid && !done, "R11 after release",
              $sformatf("%0b%0b%0b", req_ready, pass_valid, done), "100");

        for (int l = 0; l < L; l++) addr_arr[l] = 4*l + (l % 4);
        run_req('1, 2'd0, 1'b0, "R1 unit stride");
        for (int l = 0; l < L; l++) addr_arr[l] = 200 + (l % 4);
        run_req('1, 2'd0, 1'b0, "R2 broadcast");
        run_req('1, 2'd0, 1'b1, "R8 write same word");
        for (int l = 0; l < L; l++) addr_arr[l] = 128*l;
        run_req('1, 2'd0, 1'b0, "R3 R12 column walk");
        for (int l = 0; l < L; l++) addr_arr[l] = 132*l;
        run_req('1, 2'd0, 1'b0, "R12 padded walk");
        for (int l = 0; l < L; l++) addr_arr[l] = (l % 16)*4 + (l / 16)*128;
        run_req('1, 2'd3, 1'b0, "R4 two rows");
        for (int l = 0; l < L; l++) addr_arr[l] = 8*l + 4;
        run_req('1, 2'd1, 1'b0, "R5 8B stride");
        for (int l = 0; l < L; l++) addr_arr[l] = (l % 16)*8 + (l / 16)*1024;
        run_req('1, 2'd1, 1'b0, "R7 cross phase");
        for (int l = 0; l < L; l++) addr_arr[l] = 16*l;
        run_req('1, 2'd2, 1'b0, "R6 16B stride");
        for (int l = 0; l < L; l++) addr_arr[l] = 128*l;
        run_req('1, 2'd2, 1'b1, "R6 16B conflict");
        run_req('0, 2'd0, 1'b0, "R9 none active");
        run_req(32'h0000_0021, 2'd0, 1'b0, "R9 two active");
        for (int l = 0; l < L; l++) addr_arr[l] = 8*l;
        run_req(32'hFFFF_0000, 2'd1, 1'b0, "R9 empty phase");
        for (int l = 0; l < L; l++) addr_arr[l] = 36;
        run_req(32'h0000_0088, 2'd0, 1'b1, "R8 two writers");
        for (int t = 0; t < 8; t++) begin
            for (int l = 0; l < L; l++) addr_arr[l] = int'($urandom % 96) * 4 + int'($urandom % 4);
            run_req(L'($urandom), 2'(t % 3), 1'(t % 2), $sformatf("R4 random %0d", t));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule